// File: doc/BRIEF.md
# Shifter Operand Generator

This block produces the second operand of a 32-bit data-processing datapath, together with the carry that a logical instruction would write to the flags. It is purely combinational. It has two operand forms. In the immediate form, an 8-bit constant is zero-extended and rotated right by an even amount taken from a 4-bit rotate field. In the register form, a register value is shifted by one of four shift kinds.

In the register form the shift amount comes either from a 5-bit field in the instruction or from the low byte of another register. The two amount sources treat zero and oversized amounts differently. An instruction-field amount of zero is reinterpreted as a shift by the full word width, or as a one-bit rotate through the carry. A register amount is taken at face value up to a clamp. When the shifted value or the amount comes from the program counter in the register-amount form, the value is read 4 ahead.

Register-file reads, the ALU and the write-back of the flags all lie outside this block. Every result is available in the same cycle as its inputs.

Top module: `shop_operand_gen`

## Requirements
- R1: With `use_imm`=1 the operand is `imm_byte` zero-extended to 32 bits and rotated right by 2×`imm_rot`. With `imm_rot`=0 the operand is the plain zero-extended byte and `carry_out` equals `carry_in`.
- R2: With `use_imm`=1 and `imm_rot`≠0, `carry_out` equals bit 31 of the operand.
- R3: `shift_sel` encoding is 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right. For amounts 1 to 31 the result is the shifted value, and `carry_out` is the last bit shifted out. For a rotate, that last bit is bit 31 of the result.
- R4: Logical left by an instruction-field amount of 0 passes the value through with `carry_out`=`carry_in`. So does any shift kind with a register amount whose effective byte is 0.
- R5: With an instruction-field amount of 0, logical right shifts by 32, giving 0 with carry = value bit 31. Arithmetic right also shifts by 32, filling both the result and the carry with the value's bit 31.
- R6: With an instruction-field amount of 0, rotate right becomes a one-bit rotate through the carry. The result is {`carry_in`, value[31:1]} and `carry_out` = value bit 0.
- R7: With `amt_by_reg`=1 only bits [7:0] of `amt_src` set the amount. Bits [31:8] have no effect.
- R8: With a register amount, logical left or right by exactly 32 gives 0. The carry is value bit 0 for left and value bit 31 for right. Any amount of 33 to 255 gives 0 with carry 0.
- R9: With a register amount of 32 or more, arithmetic right gives all copies of value bit 31, and the carry is value bit 31.
- R10: With a register amount, rotate right by a nonzero byte whose bits [4:0] are 0 leaves the value unchanged with carry = value bit 31. Otherwise it rotates by bits [4:0].
- R11: In the register-amount form, `src_is_pc` adds 4 to `src_val` and `amt_is_pc` adds 4 to the amount byte, wrapping modulo 256. In the immediate and instruction-field-amount forms both flags have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| use_imm | input | 1 | 1 selects the rotated-constant form |
| imm_byte | input | 8 | Constant for the immediate form |
| imm_rot | input | 4 | Rotate field; rotate amount is twice this value |
| src_val | input | 32 | Register value to be shifted |
| src_is_pc | input | 1 | `src_val` was read from the program counter |
| shift_sel | input | 2 | Shift kind: 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| amt_by_reg | input | 1 | 1 takes the amount from `amt_src`, 0 from `amt_field` |
| amt_field | input | 5 | Instruction-field shift amount |
| amt_src | input | 32 | Register holding the shift amount in bits [7:0] |
| amt_is_pc | input | 1 | `amt_src` was read from the program counter |
| carry_in | input | 1 | Current carry flag |
| operand | output | 32 | Shifted or rotated operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
Assertions inside the top module check a fixed set of properties combinationally whenever the inputs change:
- the unrotated constant and its carry pass-through;
- carry equal to bit 31 after a nonzero constant rotate;
- the rotate through the carry;
- the zero result and zero carry for register amounts of 33 or more;
- the sign fill for large arithmetic shifts;
- the pass-through for a zero register amount.

Only the bench's scenarios show the in-range shift values and their exact carry bit. They also cover the boundary at exactly 32, the wrap of the biased amount byte, the ignored upper amount bits, and the 32-step rotate. The bench computes these from a bit-by-bit stepping model rather than from a barrel formula.

// File: rtl/shop_pkg.sv
package shop_pkg;

    typedef enum logic [1:0] {
        SK_LSL = 2'd0,
        SK_LSR = 2'd1,
        SK_ASR = 2'd2,
        SK_ROR = 2'd3
    } shift_kind_e;

endpackage

// File: rtl/shop_imm_prep.sv
module shop_imm_prep #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4,
    parameter int AMT_W  = 6
) (
    input  logic [IMM_W-1:0]  imm,
    input  logic [ROT_W-1:0]  rot,
    output logic [DATA_W-1:0] val,
    output logic [AMT_W-1:0]  amt
);

    // The rotate field counts pairs of bit positions.
    assign val = DATA_W'(imm);
    assign amt = AMT_W'({rot, 1'b0});

endmodule

// File: rtl/shop_amt_decode.sv
module shop_amt_decode
    import shop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SHF_W  = 5,
    parameter int RAMT_W = 8,
    parameter int AMT_W  = 6
) (
    input  logic              from_reg,
    input  shift_kind_e       kind,
    input  logic [SHF_W-1:0]  field,
    input  logic [RAMT_W-1:0] reg_amt,
    output logic [AMT_W-1:0]  amt,
    output logic              rrx
);

    localparam logic [AMT_W-1:0]  AMT_FULL = AMT_W'(DATA_W);
    localparam logic [AMT_W-1:0]  AMT_OVER = AMT_W'(DATA_W + 1);
    localparam logic [RAMT_W-1:0] RA_FULL  = RAMT_W'(DATA_W);
    localparam logic [RAMT_W-1:0] RA_TOP   = RAMT_W'(DATA_W - 1);

    always_comb begin
        amt = '0;
        rrx = 1'b0;
        if (!from_reg) begin
            unique case (kind)
                SK_LSL: amt = AMT_W'(field);
                SK_LSR,
                SK_ASR: amt = (field == '0) ? AMT_FULL : AMT_W'(field);
                SK_ROR: begin
                    amt = AMT_W'(field);
                    rrx = (field == '0);
                end
            endcase
        end else begin
            unique case (kind)
                SK_LSL,
                SK_LSR: amt = (reg_amt > RA_FULL) ? AMT_OVER : AMT_W'(reg_amt);
                SK_ASR: amt = (reg_amt > RA_TOP) ? AMT_FULL : AMT_W'(reg_amt);
                SK_ROR: begin
                    if (reg_amt == '0)
                        amt = '0;
                    else if (reg_amt[SHF_W-1:0] == '0)
                        amt = AMT_FULL;
                    else
                        amt = AMT_W'(reg_amt[SHF_W-1:0]);
                end
            endcase
        end
    end

endmodule

// File: rtl/shop_shift_core.sv
module shop_shift_core
    import shop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 6
) (
    input  shift_kind_e       kind,
    input  logic [DATA_W-1:0] val,
    input  logic [AMT_W-1:0]  amt,
    input  logic              rrx,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);

    localparam int WX = DATA_W + 1;

    // One guard bit beyond the word catches the last bit shifted out.
    logic [WX-1:0]     lsl_w;
    logic [WX-1:0]     lsr_w;
    logic [WX-1:0]     asr_w;
    logic [DATA_W-1:0] ror_w;

    assign lsl_w = {1'b0, val} << amt;
    assign lsr_w = {val, 1'b0} >> amt;
    assign asr_w = WX'($signed({val, 1'b0}) >>> amt);
    assign ror_w = DATA_W'({val, val} >> amt);

    always_comb begin
        res  = val;
        cout = cin;
        if (rrx) begin
            res  = {cin, val[DATA_W-1:1]};
            cout = val[0];
        end else if (amt != '0) begin
            unique case (kind)
                SK_LSL: begin
                    res  = lsl_w[DATA_W-1:0];
                    cout = lsl_w[DATA_W];
                end
                SK_LSR: begin
                    res  = lsr_w[DATA_W:1];
                    cout = lsr_w[0];
                end
                SK_ASR: begin
                    res  = asr_w[DATA_W:1];
                    cout = asr_w[0];
                end
                SK_ROR: begin
                    res  = ror_w;
                    cout = ror_w[DATA_W-1];
                end
            endcase
        end
    end

endmodule

// File: rtl/shop_operand_gen.sv
module shop_operand_gen
    import shop_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 8,
    parameter int ROT_W   = 4,
    parameter int SHF_W   = 5,
    parameter int RAMT_W  = 8,
    parameter int PC_BIAS = 4
) (
    input  logic              use_imm,
    input  logic [IMM_W-1:0]  imm_byte,
    input  logic [ROT_W-1:0]  imm_rot,
    input  logic [DATA_W-1:0] src_val,
    input  logic              src_is_pc,
    input  logic [1:0]        shift_sel,
    input  logic              amt_by_reg,
    input  logic [SHF_W-1:0]  amt_field,
    input  logic [DATA_W-1:0] amt_src,
    input  logic              amt_is_pc,
    input  logic              carry_in,
    output logic [DATA_W-1:0] operand,
    output logic              carry_out
);

    localparam int AMT_W = $clog2(DATA_W + 2);

    logic [DATA_W-1:0] imm_val;
    logic [AMT_W-1:0]  imm_amt;
    logic [DATA_W-1:0] src_eff;
    logic [RAMT_W-1:0] amt_eff;
    logic [AMT_W-1:0]  dec_amt;
    logic              dec_rrx;
    shift_kind_e       kind_sel;
    shift_kind_e       kind_core;
    logic [DATA_W-1:0] val_core;
    logic [AMT_W-1:0]  amt_core;
    logic              rrx_core;
    logic              unused_hi_amt;

    assign unused_hi_amt = ^amt_src[DATA_W-1:RAMT_W];
    assign kind_sel      = shift_kind_e'(shift_sel);

    // Program-counter read-ahead applies only to register-amount shifts.
    if (PC_BIAS != 0) begin : g_pc_bias
        assign src_eff = (amt_by_reg && src_is_pc) ? src_val + DATA_W'(PC_BIAS) : src_val;
        assign amt_eff = (amt_by_reg && amt_is_pc) ? amt_src[RAMT_W-1:0] + RAMT_W'(PC_BIAS)
                                                   : amt_src[RAMT_W-1:0];
    end else begin : g_no_bias
        logic unused_pc_flags;
        assign unused_pc_flags = src_is_pc ^ amt_is_pc;
        assign src_eff = src_val;
        assign amt_eff = amt_src[RAMT_W-1:0];
    end

    shop_imm_prep #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W),
        .ROT_W  (ROT_W),
        .AMT_W  (AMT_W)
    ) u_imm (
        .imm (imm_byte),
        .rot (imm_rot),
        .val (imm_val),
        .amt (imm_amt)
    );

    shop_amt_decode #(
        .DATA_W (DATA_W),
        .SHF_W  (SHF_W),
        .RAMT_W (RAMT_W),
        .AMT_W  (AMT_W)
    ) u_amt (
        .from_reg (amt_by_reg),
        .kind     (kind_sel),
        .field    (amt_field),
        .reg_amt  (amt_eff),
        .amt      (dec_amt),
        .rrx      (dec_rrx)
    );

    assign kind_core = use_imm ? SK_ROR  : kind_sel;
    assign val_core  = use_imm ? imm_val : src_eff;
    assign amt_core  = use_imm ? imm_amt : dec_amt;
    assign rrx_core  = !use_imm && dec_rrx;

    shop_shift_core #(
        .DATA_W (DATA_W),
        .AMT_W  (AMT_W)
    ) u_core (
        .kind (kind_core),
        .val  (val_core),
        .amt  (amt_core),
        .rrx  (rrx_core),
        .cin  (carry_in),
        .res  (operand),
        .cout (carry_out)
    );

    // Port-level checks of the special encodings.
    always_comb begin
        if (use_imm && imm_rot == '0) begin
            a_r1_imm_plain: assert (operand == DATA_W'(imm_byte) && carry_out == carry_in)
                else $error("R1 unrotated constant mismatch");
        end
        if (use_imm && imm_rot != '0) begin
            a_r2_imm_carry: assert (carry_out == operand[DATA_W-1])
                else $error("R2 rotate carry mismatch");
        end
        if (!use_imm && !amt_by_reg && kind_sel == SK_ROR && amt_field == '0) begin
            a_r6_rrx: assert (operand == {carry_in, src_val[DATA_W-1:1]} && carry_out == src_val[0])
                else $error("R6 rotate-through-carry mismatch");
        end
        if (!use_imm && amt_by_reg && (kind_sel == SK_LSL || kind_sel == SK_LSR)
            && amt_eff > RAMT_W'(DATA_W)) begin
            a_r8_far_zero: assert (operand == '0 && !carry_out)
                else $error("R8 far shift not zero");
        end
        if (!use_imm && amt_by_reg && kind_sel == SK_ASR && amt_eff >= RAMT_W'(DATA_W)) begin
            a_r9_sign_fill: assert (operand == {DATA_W{src_eff[DATA_W-1]}}
                                    && carry_out == src_eff[DATA_W-1])
                else $error("R9 sign fill mismatch");
        end
        if (!use_imm && amt_by_reg && amt_eff == '0) begin
            a_r4_zero_pass: assert (operand == src_eff && carry_out == carry_in)
                else $error("R4 zero amount not passed through");
        end
    end

endmodule

// File: tb/tb_shop_operand_gen.sv
module tb_shop_operand_gen;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        use_imm = 1'b0;
    logic [7:0]  imm_byte = '0;
    logic [3:0]  imm_rot = '0;
    logic [31:0] src_val = '0;
    logic        src_is_pc = 1'b0;
    logic [1:0]  shift_sel = '0;
    logic        amt_by_reg = 1'b0;
    logic [4:0]  amt_field = '0;
    logic [31:0] amt_src = '0;
    logic        amt_is_pc = 1'b0;
    logic        carry_in = 1'b0;
    logic [31:0] operand;
    logic        carry_out;

    typedef struct {
        logic [31:0] v;
        logic        c;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shop_operand_gen dut (
        .use_imm    (use_imm),
        .imm_byte   (imm_byte),
        .imm_rot    (imm_rot),
        .src_val    (src_val),
        .src_is_pc  (src_is_pc),
        .shift_sel  (shift_sel),
        .amt_by_reg (amt_by_reg),
        .amt_field  (amt_field),
        .amt_src    (amt_src),
        .amt_is_pc  (amt_is_pc),
        .carry_in   (carry_in),
        .operand    (operand),
        .carry_out  (carry_out)
    );

    // Step-by-step model: one bit position per iteration.
    function automatic void step_model(input int kind, input logic [31:0] v, input int n,
                                       input logic cin, output logic [31:0] r, output logic c);
        r = v;
        c = cin;
        for (int i = 0; i < n; i++) begin
            case (kind)
                0: begin c = r[31]; r = {r[30:0], 1'b0}; end
                1: begin c = r[0];  r = {1'b0, r[31:1]}; end
                2: begin c = r[0];  r = {r[31], r[31:1]}; end
                default: begin c = r[0]; r = {r[0], r[31:1]}; end
            endcase
        end
    endfunction

    function automatic void ref_model(output logic [31:0] r, output logic c);
        logic [7:0] b;
        int n;
        if (use_imm) begin
            step_model(3, {24'd0, imm_byte}, 2 * int'(imm_rot), carry_in, r, c);
        end else if (!amt_by_reg) begin
            n = int'(amt_field);
            if (shift_sel == 2'd3 && n == 0) begin
                r = {carry_in, src_val[31:1]};
                c = src_val[0];
            end else begin
                if ((shift_sel == 2'd1 || shift_sel == 2'd2) && n == 0) n = 32;
                step_model(int'(shift_sel), src_val, n, carry_in, r, c);
            end
        end else begin
            b = amt_src[7:0] + (amt_is_pc ? 8'd4 : 8'd0);
            if (shift_sel == 2'd3)
                n = (b == 0) ? 0 : ((b[4:0] == 0) ? 32 : int'(b[4:0]));
            else
                n = int'(b);
            step_model(int'(shift_sel), src_val + (src_is_pc ? 32'd4 : 32'd0), n, carry_in, r, c);
        end
    endfunction

    task automatic apply(input logic ui, input logic [7:0] ib, input logic [3:0] ir,
                         input logic [31:0] sv, input logic spc, input logic [1:0] sel,
                         input logic br, input logic [4:0] af, input logic [31:0] as,
                         input logic apc, input logic ci);
        @(posedge clk);
        use_imm = ui; imm_byte = ib; imm_rot = ir; src_val = sv; src_is_pc = spc;
        shift_sel = sel; amt_by_reg = br; amt_field = af; amt_src = as;
        amt_is_pc = apc; carry_in = ci;
    endtask

    task automatic expect_lit(input logic [31:0] v, input logic c, input string tag);
        exp_t e;
        e.v = v; e.c = c; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic expect_model(input string tag);
        exp_t e;
        ref_model(e.v, e.c);
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: results are compared half a cycle after the inputs change.
    always @(negedge clk) begin
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (operand !== e.v || carry_out !== e.c) begin
                errors++;
                $display("FAIL %s: operand=%h carry=%b expected operand=%h carry=%b",
                         e.tag, operand, carry_out, e.v, e.c);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run incomplete (actual timeout, expected completion)");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state: all-zero inputs pass zero through (R4).
        apply(0, 8'h00, 4'h0, 32'h0, 0, 2'd0, 0, 5'd0, 32'h0, 0, 0);
        expect_lit(32'h0, 1'b0, "R4 idle");
        // R1 and R2: rotated constant.
        apply(1, 8'hAB, 4'h0, 32'hDEAD_BEEF, 0, 2'd1, 0, 5'd3, 32'h0, 0, 1);
        expect_lit(32'h0000_00AB, 1'b1, "R1 no rotate");
        apply(1, 8'h3F, 4'h1, 32'h0, 0, 2'd0, 0, 5'd0, 32'h0, 0, 0);
        expect_lit(32'hC000_000F, 1'b1, "R2 rotate by 2");
        apply(1, 8'hFF, 4'h4, 32'h0, 0, 2'd0, 0, 5'd0, 32'h0, 0, 0);
        expect_lit(32'hFF00_0000, 1'b1, "R2 rotate by 8");
        apply(1, 8'h01, 4'h1, 32'h0, 0, 2'd0, 0, 5'd0, 32'h0, 0, 1);
        expect_lit(32'h4000_0000, 1'b0, "R2 carry clear");
        // R3: in-range shifts.
        apply(0, 8'h0, 4'h0, 32'h1000_0001, 0, 2'd0, 0, 5'd4, 32'h0, 0, 0);
        expect_lit(32'h0000_0010, 1'b1, "R3 lsl 4");
        apply(0, 8'h0, 4'h0, 32'h8000_0010, 0, 2'd2, 0, 5'd5, 32'h0, 0, 0);
        expect_lit(32'hFC00_0000, 1'b1, "R3 asr 5");
        // R4 and R5, R6: instruction-field zero encodings.
        apply(0, 8'h0, 4'h0, 32'h1234_5678, 0, 2'd0, 0, 5'd0, 32'h0, 0, 1);
        expect_lit(32'h1234_5678, 1'b1, "R4 lsl 0");
        apply(0, 8'h0, 4'h0, 32'h8000_0000, 0, 2'd1, 0, 5'd0, 32'h0, 0, 0);
        expect_lit(32'h0, 1'b1, "R5 lsr 32");
        apply(0, 8'h0, 4'h0, 32'h8000_0000, 0, 2'd2, 0, 5'd0, 32'h0, 0, 0);
        expect_lit(32'hFFFF_FFFF, 1'b1, "R5 asr 32");
        apply(0, 8'h0, 4'h0, 32'h0000_0003, 0, 2'd3, 0, 5'd0, 32'h0, 0, 1);
        expect_lit(32'h8000_0001, 1'b1, "R6 rrx");
        // R7: upper amount bits ignored.
        apply(0, 8'h0, 4'h0, 32'h1, 0, 2'd0, 1, 5'd0, 32'hFFFF_FF04, 0, 0);
        expect_lit(32'h10, 1'b0, "R7 low byte only");
        // R8: register amounts at and beyond the word.
        apply(0, 8'h0, 4'h0, 32'h1, 0, 2'd0, 1, 5'd0, 32'd32, 0, 0);
        expect_lit(32'h0, 1'b1, "R8 lsl 32");
        apply(0, 8'h0, 4'h0, 32'h8000_0000, 0, 2'd1, 1, 5'd0, 32'd32, 0, 0);
        expect_lit(32'h0, 1'b1, "R8 lsr 32");
        apply(0, 8'h0, 4'h0, 32'hFFFF_FFFF, 0, 2'd0, 1, 5'd0, 32'd33, 0, 1);
        expect_lit(32'h0, 1'b0, "R8 lsl 33");
        apply(0, 8'h0, 4'h0, 32'hFFFF_FFFF, 0, 2'd1, 1, 5'd0, 32'd200, 0, 1);
        expect_lit(32'h0, 1'b0, "R8 lsr 200");
        // R9: large arithmetic shifts.
        apply(0, 8'h0, 4'h0, 32'h8000_0000, 0, 2'd2, 1, 5'd0, 32'd100, 0, 0);
        expect_lit(32'hFFFF_FFFF, 1'b1, "R9 asr 100 neg");
        apply(0, 8'h0, 4'h0, 32'h7FFF_FFFF, 0, 2'd2, 1, 5'd0, 32'd32, 0, 1);
        expect_lit(32'h0, 1'b0, "R9 asr 32 pos");
        // R10: register rotates.
        apply(0, 8'h0, 4'h0, 32'h8000_0001, 0, 2'd3, 1, 5'd0, 32'd32, 0, 0);
        expect_lit(32'h8000_0001, 1'b1, "R10 ror 32");
        apply(0, 8'h0, 4'h0, 32'h8000_0001, 0, 2'd3, 1, 5'd0, 32'd64, 0, 0);
        expect_lit(32'h8000_0001, 1'b1, "R10 ror 64");
        apply(0, 8'h0, 4'h0, 32'h0000_00F0, 0, 2'd3, 1, 5'd0, 32'd36, 0, 1);
        expect_lit(32'h0000_000F, 1'b0, "R10 ror 36");
        apply(0, 8'h0, 4'h0, 32'h1, 0, 2'd3, 1, 5'd0, 32'h0, 0, 1);
        expect_lit(32'h1, 1'b1, "R4 ror reg 0");
        // R11: program-counter read-ahead.
        apply(0, 8'h0, 4'h0, 32'h100, 1, 2'd0, 1, 5'd0, 32'h0, 0, 0);
        expect_lit(32'h104, 1'b0, "R11 value bias");
        apply(0, 8'h0, 4'h0, 32'h1, 0, 2'd0, 1, 5'd0, 32'h0, 1, 0);
        expect_lit(32'h10, 1'b0, "R11 amount bias");
        apply(0, 8'h0, 4'h0, 32'h5, 0, 2'd1, 1, 5'd0, 32'hFC, 1, 1);
        expect_lit(32'h5, 1'b1, "R11 amount wrap");
        apply(0, 8'h0, 4'h0, 32'h100, 1, 2'd0, 0, 5'd0, 32'h0, 1, 0);
        expect_lit(32'h100, 1'b0, "R11 ignored in field form");
        apply(1, 8'h12, 4'h0, 32'h0, 1, 2'd0, 1, 5'd0, 32'h0, 1, 0);
        expect_lit(32'h12, 1'b0, "R11 ignored in immediate form");
        // Sweep against the stepping model.
        for (int i = 0; i < 600; i++) begin
            logic [31:0] a;
            logic [31:0] b;
            a = $urandom;
            b = $urandom;
            apply(a[0] & a[1], a[15:8], a[19:16], b, a[2], a[5:4], a[6], a[28:24],
                  {a[31:20], 12'h0, 3'b000, a[7] ? a[23:20] : 4'h0, a[9:8]} ^ {24'h0, b[7:0]},
                  a[3], a[30]);
            if (use_imm)          expect_model("R2 sweep");
            else if (amt_by_reg)  expect_model("R8 sweep");
            else                  expect_model("R3 sweep");
        end
        while (sb.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule